// File: doc/BRIEF.md
# Grouped External Interrupt Sense Unit

This unit conditions a set of input pins that share one external interrupt vector. A static per-pin enable mask selects which pins belong to the group. Each pin passes through a synchronizer. The enabled, synchronized pins are combined with a logical AND, and that single combined signal feeds a detector. A two-bit sense field sets the detector's sensitivity to rising edges, falling edges, both edges, or a low level.

In the edge modes, a detected edge is held in a pending latch. The request therefore survives while the core has interrupts masked. The latch clears when the core pulses its handler-entry acknowledge. In level mode the request follows the combined signal directly and is not stored. The unit drives a request line to the interrupt controller and a wake line that lets the core leave halt.

The unit has no data stream, so it has no valid/ready interface. Every pin is a plain control or status signal.

Top module: `xirq_sense`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `irq_o` and `wake_o` are 0. The synchronizer and the previous-value register reset to the idle-high state, so releasing reset with all pins high creates no edge.
- R2: The combined signal is the AND of the synchronized pins whose `grp_en_i` bit is 1. A pin whose enable bit is 0 has no effect on the outputs. With no pin enabled, the combined signal is 1 and no request is raised in any mode.
- R3: With `sense_i` = 2'b01, a 0-to-1 change of the combined signal sets the pending latch. A 1-to-0 change does not set it.
- R4: With `sense_i` = 2'b10, a 1-to-0 change of the combined signal sets the pending latch. A 0-to-1 change does not set it.
- R5: With `sense_i` = 2'b11, a change of the combined signal in either direction sets the pending latch.
- R6: With `sense_i` = 2'b00, `irq_o` is 1 exactly while the combined signal is 0. The request is not latched, and `ack_i` has no effect. The pending latch is held clear in this mode.
- R7: In an edge mode, a set latch keeps `irq_o` at 1 until `ack_i` is sampled at 1. `irq_o` is 0 from the next cycle on, unless a new edge arrives.
- R8: If an edge is detected in the same cycle that `ack_i` is 1, the latch stays set. The new edge is not lost.
- R9: A pin change driven before clock edge k sets `irq_o` after edge k+2 in the edge modes. In level mode it shows after edge k+1.
- R10: Any enabled pin held low forces the combined signal low. This blocks a rising-edge request even when another enabled pin rises.
- R11: `wake_o` equals `irq_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous pin levels |
| grp_en_i | input | NPINS | Static group membership and enable mask, one bit per pin |
| sense_i | input | 2 | Sensitivity: 00 low level, 01 rising, 10 falling, 11 both edges |
| ack_i | input | 1 | One-cycle pulse from the core on entry to this source's handler |
| irq_o | output | 1 | Request to the interrupt controller |
| wake_o | output | 1 | Halt-exit indication |

## Verification
A stuck or wrongly cleared pending latch shows on `irq_o` and `wake_o` on the cycle after the acknowledge or the edge that should have changed it. A wrong masking term in the AND shows as a missing or extra request three clocks after the pin moves. A wrong previous-value register shows as a spurious request right after reset, or as a request for an edge of the wrong polarity. A synchronizer of the wrong depth moves the request by one cycle, and the bench samples the exact cycle to catch it.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_ANY  = 2'b11
  } sense_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int NPINS  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw_i,
  output logic [NPINS-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_i[p]};
    end
    assign sync_o[p] = chain_q[LAST];
  end
endmodule

// File: rtl/xirq_combine.sv
module xirq_combine #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] en_i,
  output logic             comb_o
);
  logic [NPINS-1:0] masked;

  for (genvar p = 0; p < NPINS; p++) begin : g_mask
    assign masked[p] = en_i[p] ? sync_i[p] : 1'b1;
  end

  assign comb_o = &masked;

  // R10: one enabled low pin blocks the group
  p_low_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_i & ~sync_i)) |-> !comb_o);

  // R2: an empty group idles high
  p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> comb_o);
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   comb_i,
  input  sense_e sense_i,
  input  logic   ack_i,
  output logic   req_o
);
  logic prev_q;
  logic pend_q;
  logic rise, fall, hit;

  assign rise = comb_i & ~prev_q;
  assign fall = ~comb_i & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_RISE: hit = rise;
      SENSE_FALL: hit = fall;
      SENSE_ANY:  hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= comb_i;
      if (sense_i == SENSE_LOW) pend_q <= 1'b0;
      else if (hit)             pend_q <= 1'b1;
      else if (ack_i)           pend_q <= 1'b0;
    end
  end

  assign req_o = (sense_i == SENSE_LOW) ? ~comb_i : pend_q;

  // R7: acknowledge without a new edge drops the request
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack_i && !hit) |=> !pend_q);

  // R7: without acknowledge the request holds in edge modes
  p_pend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i && sense_i != SENSE_LOW) |=> pend_q);

  // R8: a new edge wins over a coincident acknowledge
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ack_i) |=> pend_q);
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
  import xirq_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] grp_en_i,
  input  logic [1:0]       sense_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NPINS-1:0] pin_sync;
  logic             comb;
  sense_e           sense;

  assign sense = sense_e'(sense_i);

  xirq_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(pin_sync)
  );

  xirq_combine #(.NPINS(NPINS)) u_comb (
    .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .en_i(grp_en_i), .comb_o(comb)
  );

  xirq_detect u_det (
    .clk(clk), .rst_n(rst_n), .comb_i(comb), .sense_i(sense),
    .ack_i(ack_i), .req_o(irq_o)
  );

  assign wake_o = irq_o;

  // R6: in level mode the request tracks the combined signal, acknowledge or not
  p_level_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LOW && !comb) |-> irq_o);
endmodule

// File: tb/xirq_sense_bench.sv
module xirq_sense_bench;
  localparam int NP = 4;
  localparam int NV = 25;
  // vector = {sense[11:10], en[9:6], pins[5:2], ack[1], expected irq[0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b01_0011_1111_0_0, // R1 idle after reset
    12'b01_0011_1110_0_0, // R3 fall ignored
    12'b01_0011_1111_0_1, // R3 rise sets
    12'b01_0011_1111_0_1, // R7 holds
    12'b01_0011_1111_1_0, // R7 ack clears
    12'b01_0011_0111_0_0, // R2 disabled pin ignored
    12'b01_0011_1111_0_0, // R2
    12'b01_0011_1101_0_0, // R10 pin1 low
    12'b01_0011_1100_0_0, // R10
    12'b01_0011_1110_0_0, // R10 pin1 rises, pin0 masks
    12'b01_0011_1111_0_1, // R10 group rises
    12'b01_0011_1111_1_0,
    12'b10_0011_1110_0_1, // R4 fall sets
    12'b10_0011_1110_1_0,
    12'b10_0011_1111_0_0, // R4 rise ignored
    12'b11_0011_1110_0_1, // R5 fall
    12'b11_0011_1110_1_0,
    12'b11_0011_1111_0_1, // R5 rise
    12'b11_0011_1111_1_0,
    12'b00_0011_1111_0_0, // R6 high
    12'b00_0011_1110_0_1, // R6 low
    12'b00_0011_1110_1_1, // R6 ack no effect
    12'b00_0011_1111_0_0, // R6 not latched
    12'b00_0000_0000_0_0, // R2 empty group
    12'b11_0000_1111_0_0  // R2 empty group
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '1;
  logic [NP-1:0] en = 4'b0011;
  logic [1:0]    sense = 2'b01;
  logic          ack = 1'b0;
  logic          irq, wake;
  int            checks = 0;
  int            fails = 0;
  int            cyc = 0;

  always #10 clk = ~clk;

  xirq_sense #(.NPINS(NP), .SYNC_STAGES(2)) u_xirq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .grp_en_i(en), .sense_i(sense),
    .ack_i(ack), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b t=%0t", tag, irq, exp, $time);
    end
    checks++;
    if (wake !== irq) begin // R11
      fails++;
      $display("FAIL R11 wake actual=%b expected=%b t=%0t", wake, irq, $time);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    check("R1", 1'b0);
    rst_n = 1'b1;
    wait_n(1);
    check("R1", 1'b0);
    for (int v = 0; v < NV; v++) begin
      sense = VEC[v][11:10];
      en    = VEC[v][9:6];
      pin   = VEC[v][5:2];
      ack   = VEC[v][1];
      wait_n(1);
      ack = 1'b0;
      wait_n(3);
      check(mode_tag(VEC[v][11:10]), VEC[v][0]);
    end
    // R8: edge coincident with acknowledge
    sense = 2'b01; en = 4'b0001; pin = 4'b0000; wait_n(4);
    pin = 4'b0001; wait_n(4);
    check("R3", 1'b1);
    pin = 4'b0000; wait_n(4);
    check("R7", 1'b1);
    pin = 4'b0001;
    wait_n(2);
    ack = 1'b1;
    wait_n(1);
    ack = 1'b0;
    check("R8", 1'b1);
    ack = 1'b1; wait_n(1); ack = 1'b0; wait_n(1);
    check("R7", 1'b0);
    // R9: edge-mode latency
    pin = 4'b0000; wait_n(4);
    pin = 4'b0001;
    wait_n(1); check("R9", 1'b0);
    wait_n(1); check("R9", 1'b0);
    wait_n(1); check("R9", 1'b1);
    ack = 1'b1; wait_n(1); ack = 1'b0; wait_n(1);
    check("R7", 1'b0);
    // R9: level-mode latency
    sense = 2'b00; wait_n(4);
    check("R6", 1'b0);
    pin = 4'b0000;
    wait_n(1); check("R9", 1'b0);
    wait_n(1); check("R9", 1'b1);
    // R1: reset mid-run clears the request
    rst_n = 1'b0; wait_n(1);
    check("R1", 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule